// File: doc/BRIEF.md
# Indexed Block-Copy Sequencer

This block copies a run of consecutive memory words from one region to another, one word at a time. A single start pulse supplies three values: the number of words to copy, the source base address (already summed with an index register upstream), and the destination pointer register. The engine reads each source word and writes it to the location the destination pointer names. It advances both addresses after each word. When the count runs out, it raises a one-cycle done pulse and holds the advanced destination pointer on its output, so the pointer can be written back as a live architectural register.

The memory port is single-ported and synchronous. `mem_rd_data` is valid in the cycle after the cycle in which `mem_rd_en` was high. Every word takes one read cycle followed by one write cycle, so copies between overlapping regions behave exactly like a forward loop of single-word copies. Both addresses wrap modulo `MEM_DEPTH`.

The controller has four states:
- IDLE: waiting for a start pulse.
- READ: the source word is requested.
- WRITE: the returned word is written to the destination.
- FINISH: the done pulse is raised.

The transitions are:
- IDLE→READ on a start pulse with a non-zero count.
- IDLE→FINISH on a start pulse with a zero count.
- READ→WRITE always.
- WRITE→READ while words remain.
- WRITE→FINISH after the last word.
- FINISH→IDLE always.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0 and `dst_ptr` is 0.
- R2: For a count N, word n (0 ≤ n < N) is read from (src + n) mod MEM_DEPTH and the value returned is written to (dst + n) mod MEM_DEPTH.
- R3: Words are copied in increasing n. When the destination is one above the source, the first source word is replicated across the whole destination run.
- R4: After a copy, `dst_ptr` equals (dst + N) mod MEM_DEPTH and keeps that value until the next accepted start.
- R5: A count of zero performs no memory access, raises done on the first cycle after the accepting edge, and leaves `dst_ptr` equal to the supplied destination.
- R6: `busy` is high from the edge that accepts start through the done cycle. `done` is high after the (2N+1)-th clock edge counted from the accepting edge (that edge included).
- R7: A start pulse while `busy` is high is ignored and does not alter the copy in progress.
- R8: Reads and writes never occur in the same cycle. A copy of N words makes exactly N reads and N writes, and every write follows a read cycle.
- R9: Source and destination addresses wrap from MEM_DEPTH-1 to 0.
- R10: `done` is high for exactly one cycle, after which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_count | input | CNT_W | Number of words to copy |
| start_src | input | ADDR_W | Indexed source base address |
| start_dst | input | ADDR_W | Destination pointer register value |
| busy | output | 1 | High while a copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_ptr | output | ADDR_W | Live destination pointer register |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_wr_data | output | DATA_W | Write data |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the request |

## Verification
Internal faults in this block show up quickly at the ports:
- A corrupted remaining-word count shifts the done pulse away from edge 2N+1 and changes the number of reads and writes. This is visible at the end of the same copy.
- A pointer that steps at the wrong time or wraps wrongly writes a wrong memory word, or leaves `dst_ptr` at the wrong value. This is visible in the whole-memory comparison taken right after done.
- A state machine that leaves IDLE on a start pulse while busy either corrupts the memory image or prolongs the busy window. This is visible within the current copy.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } copy_state_t;
endpackage

// File: rtl/blkcopy_ptr.sv
module blkcopy_ptr #(
    parameter int MEM_DEPTH = 64,
    parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_DEPTH - 1);

    logic [ADDR_W-1:0] ptr_inc;

    // modulo-depth increment, valid for any depth
    always_comb begin
        if (ptr == LAST) ptr_inc = '0;
        else             ptr_inc = ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (load)  ptr <= load_val;
        else if (step)  ptr <= ptr_inc;
    end

    // R9: the pointer never leaves the memory range
    a_r9_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
    // R9: a step from the top address lands on zero
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == LAST) |=> ptr == '0);
endmodule

// File: rtl/blkcopy_fsm.sv
module blkcopy_fsm
    import blkcopy_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             load,
    output logic             rd_en,
    output logic             wr_en,
    output logic             done,
    output logic             busy
);
    copy_state_t      state, state_nxt;
    logic [CNT_W-1:0] remaining;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // words still to copy
    always_ff @(posedge clk) begin
        if (!rst_n)     remaining <= '0;
        else if (load)  remaining <= count;
        else if (wr_en) remaining <= remaining - 1'b1;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start) state_nxt = (count == '0) ? ST_FINISH : ST_READ;
            ST_READ:   state_nxt = ST_WRITE;
            ST_WRITE:  state_nxt = (remaining == CNT_W'(1)) ? ST_FINISH : ST_READ;
            ST_FINISH: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        rd_en = 1'b0;
        wr_en = 1'b0;
        done  = 1'b0;
        busy  = 1'b1;
        unique case (state)
            ST_IDLE:   begin busy = 1'b0; load = start; end
            ST_READ:   rd_en = 1'b1;
            ST_WRITE:  wr_en = 1'b1;
            ST_FINISH: done  = 1'b1;
        endcase
    end

    // R8: a transfer phase never runs with an empty count
    a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ || state == ST_WRITE) |-> remaining != '0);
    // R10: done is a single-cycle pulse followed by idle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R5: a zero count goes straight to the done cycle
    a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (load && count == '0) |=> done);
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
    parameter int MEM_DEPTH = 64,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 6,
    localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [ADDR_W-1:0] start_src,
    input  logic [ADDR_W-1:0] start_dst,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic [DATA_W-1:0] mem_rd_data
);
    logic              load;
    logic [ADDR_W-1:0] src_ptr;

    blkcopy_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .count (start_count),
        .load  (load),
        .rd_en (mem_rd_en),
        .wr_en (mem_wr_en),
        .done  (done),
        .busy  (busy)
    );

    // source walks after each read, destination after each write
    blkcopy_ptr #(.MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (start_src),
        .step     (mem_rd_en),
        .ptr      (src_ptr)
    );

    blkcopy_ptr #(.MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (start_dst),
        .step     (mem_wr_en),
        .ptr      (dst_ptr)
    );

    assign mem_addr    = mem_wr_en ? dst_ptr : src_ptr;
    assign mem_wr_data = mem_rd_data;

    // R8: single port, one access kind per cycle
    a_r8_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    // R8: every write is fed by the read of the previous cycle
    a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));
    // R4: the destination pointer holds while idle
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dst_ptr));
    // R6: an accepted start raises busy on the next cycle
    a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R7: a start while busy never reloads the destination pointer
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !mem_wr_en) |=> $stable(dst_ptr));
endmodule

// File: tb/blkcopy_engine_bench.sv
module blkcopy_engine_bench;
    localparam int DEPTH = 64;
    localparam int DW    = 16;
    localparam int CW    = 6;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] start_count = '0;
    logic [AW-1:0] start_src = '0;
    logic [AW-1:0] start_dst = '0;
    logic          busy, done, mem_rd_en, mem_wr_en;
    logic [AW-1:0] dst_ptr, mem_addr;
    logic [DW-1:0] mem_wr_data;
    logic [DW-1:0] mem_rd_data = '0;

    logic [DW-1:0] mem   [DEPTH];
    logic [DW-1:0] shadow[DEPTH];

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int both_cnt = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    blkcopy_engine #(.MEM_DEPTH(DEPTH), .DATA_W(DW), .CNT_W(CW)) u_blkcopy_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
        .start_src(start_src), .start_dst(start_dst), .busy(busy), .done(done),
        .dst_ptr(dst_ptr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data)
    );

    // synchronous single-port memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
        if (mem_wr_en) wr_cnt <= wr_cnt + 1;
        if (mem_rd_en && mem_wr_en) both_cnt <= both_cnt + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_copy(input int n, input int s, input int d, input int seed,
                            input bit poke, input string mem_tag);
        int lat;
        int mism;
        logic [AW-1:0] ptr_seen;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]    = DW'(i * 97 + seed * 13 + 5);
            shadow[i] = mem[i];
        end
        // forward loop reference
        for (int k = 0; k < n; k++)
            shadow[(d + k) % DEPTH] = shadow[(s + k) % DEPTH];
        rd_cnt = 0;
        wr_cnt = 0;
        both_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        start_count = CW'(n);
        start_src = AW'(s);
        start_dst = AW'(d);
        @(negedge clk);
        start = 1'b0;
        check("R6 busy after accept", 64'(busy), 1);
        lat = 0;
        while (!done && lat < 400) begin
            if (poke && lat == 2) begin
                start = 1'b1;
                start_count = CW'(40);
                start_src = AW'((s + 7) % DEPTH);
                start_dst = AW'((d + 23) % DEPTH);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (!done) check("R6 busy during copy", 64'(busy), 1);
            lat++;
        end
        start = 1'b0;
        check(n == 0 ? "R5 zero-count latency" : "R6 done latency", lat, 2 * n);
        check("R6 busy in done cycle", 64'(busy), 1);
        check("R4 dst_ptr advanced", 64'(dst_ptr), (d + n) % DEPTH);
        @(negedge clk);
        check("R10 done single cycle", 64'(done), 0);
        check("R10 idle after done", 64'(busy), 0);
        check(n == 0 ? "R5 no reads" : "R8 read count", rd_cnt, n);
        check(n == 0 ? "R5 no writes" : "R8 write count", wr_cnt, n);
        check("R8 no simultaneous access", both_cnt, 0);
        mism = 0;
        for (int i = 0; i < DEPTH; i++)
            if (mem[i] !== shadow[i]) mism++;
        check(mem_tag, mism, 0);
        ptr_seen = dst_ptr;
        repeat (4) @(negedge clk);
        check("R4 dst_ptr held", 64'(dst_ptr), 64'(ptr_seen));
        check("R7 no restart", rd_cnt + wr_cnt, 2 * n);
    endtask

    initial begin
        int counts[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 31, 63};
        repeat (3) @(negedge clk);
        check("R1 busy", 64'(busy), 0);
        check("R1 done", 64'(done), 0);
        check("R1 rd_en", 64'(mem_rd_en), 0);
        check("R1 wr_en", 64'(mem_wr_en), 0);
        check("R1 dst_ptr", 64'(dst_ptr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 12; c++) begin
            run_copy(counts[c], 0, 20, c, 1'b0, "R2 disjoint image");
            run_copy(counts[c], 10, 11, c + 1, 1'b0, "R3 forward overlap image");
            run_copy(counts[c], 11, 10, c + 2, 1'b0, "R3 backward overlap image");
            run_copy(counts[c], 58, 3, c + 3, 1'b0, "R9 source wrap image");
            run_copy(counts[c], 40, 61, c + 4, 1'b0, "R9 destination wrap image");
            if (counts[c] >= 2)
                run_copy(counts[c], 5, 30, c + 5, 1'b1, "R7 image with ignored start");
        end
        // R3: replication when destination sits one above source
        run_copy(8, 16, 17, 9, 1'b0, "R3 replication image");
        check("R3 replicated word", 64'(mem[24]), 64'(mem[16]));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule